// File: doc/BRIEF.md
# Write-Combining Line Buffer

This block sits between a processor store port and a memory bus and holds at most one cache line of uncacheable store data. Each store brings its region attributes and the cache-disable and write-through flags from its page mapping. The block ORs the two sets together and picks one of four handling policies for that store. Under the combine policy, bytes land in the open line freely and a later write to a byte replaces the earlier one. Under the burst policy, a store merges only if it climbs above every byte already held. Under the serialize policy, every store goes out alone and no more bus writes may be outstanding than a small programmable limit allows. Any other store bypasses the buffer as a single write.

The buffer empties as one bus write carrying a 32-bit byte-valid mask. This happens when a store cannot merge, when a store arrives under a different policy, or when a flush is requested. The store that caused the drain is taken in the cycle after the drain write is handed to the bus. The bus side is a valid/ready write channel plus a completion pulse, which decrements the count of outstanding writes.

Top module: `storeMergeBuffer`

## Requirements
- R1: Effective cache-disable is `regCd | pageCd` and effective write-through is `regWt | pageWt`. With effective cache-disable clear, a store is a single write. With it set, the policy is chosen as follows: `regWc=1` with effective write-through clear selects combine; `regWc=1` with effective write-through set selects burst; `regWc=0` with `regWs=1` selects serialize; anything else is a single write.
- R2: A combine store to the line held by a combine-mode buffer is accepted in the same cycle and merged. A byte written twice carries only the latest value. The whole line reaches the bus as one write.
- R3: A burst store merges only when four conditions hold: the buffer is in burst mode, the store is in the same line, its lowest enabled byte offset is above the highest offset already held, and it overlaps no held byte. Otherwise the buffer drains first.
- R4: In burst mode, two stores to the same byte are never collapsed. Each reaches the bus in its own write.
- R5: A drain happens on a store to another line, on a store under another policy, or on `flushReq` while the buffer holds data. A drain holds `stAccept` low. The waiting store is accepted in the cycle after the drain handshake, and the buffer is then empty.
- R6: A serialize store is issued directly only while the outstanding count is below `max(wsLimit,1)`, and stalls otherwise. The count rises on each bus handshake (`busVal && busRdy`) and falls on each `busDone` pulse.
- R7: A single-write store is issued directly, with its own byte mask, after any buffered data has drained.
- R8: After reset, `busVal` and `stAccept` are low, the buffer is empty and the outstanding count is zero.
- R9: In a bus write, `busAddr` is the line address with its low 5 bits zero. `busBe[i]` enables byte offset i. Byte i of the data sits in `busData[8i+7:8i]`, and disabled bytes read as zero. A store's 4 data bytes map to offsets `4*stAddr[4:2]+k`. `busVal` stays high until `busRdy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stVal | input | 1 | Store request valid |
| stAccept | output | 1 | Store taken this cycle |
| stAddr | input | 32 | Store byte address, word aligned |
| stBe | input | 4 | Store byte enables |
| stData | input | 32 | Store data |
| regCd | input | 1 | Region cache-disable |
| regWt | input | 1 | Region write-through |
| regWc | input | 1 | Region write-combine |
| regWs | input | 1 | Region write-serialize |
| pageCd | input | 1 | Page cache-disable flag |
| pageWt | input | 1 | Page write-through flag |
| flushReq | input | 1 | Drain request |
| wsLimit | input | 3 | Outstanding-write limit (0 acts as 1) |
| busVal | output | 1 | Bus write valid |
| busRdy | input | 1 | Bus accepts write |
| busAddr | output | 32 | Line address of write |
| busBe | output | 32 | Byte mask of write |
| busData | output | 256 | Line data of write |
| busDone | input | 1 | One bus write completed |

## Verification
The bench builds the block with its default parameters: a 32-byte line fed by 4-byte stores, a 3-bit limit and a 4-bit outstanding counter. With a short line, only eight word slots separate the first store from a line change, so the bench hits the descending, overlapping and line-crossing burst cases within a few stores. Every limit value, 0 and 2 among them, can be driven from the port, and the bench fills the counter to the cap by withholding completions. A behavioural byte-array model is compared with all outputs on every clock, under bus back-pressure as well.

// File: rtl/smbPkg.sv
package smbPkg;

  typedef enum logic [1:0] {
    MODE_SINGLE  = 2'd0,
    MODE_COMBINE = 2'd1,
    MODE_BURST   = 2'd2,
    MODE_SERIAL  = 2'd3
  } wrMode_e;

  typedef struct packed {
    logic loadStore;
    logic newLine;
    logic clearBuf;
    logic selDirect;
  } dpCtl_t;

  function automatic wrMode_e resolveMode(input logic cdR, input logic wtR,
                                          input logic wc, input logic ws,
                                          input logic cdP, input logic wtP);
    logic effCd;
    logic effWt;
    effCd = cdR | cdP;
    effWt = wtR | wtP;
    if (!effCd) return MODE_SINGLE;
    if (wc) return effWt ? MODE_BURST : MODE_COMBINE;
    if (ws) return MODE_SERIAL;
    return MODE_SINGLE;
  endfunction

endpackage

// File: rtl/smbData.sv
module smbData
  import smbPkg::*;
#(
  parameter int LINE_BYTES  = 32,
  parameter int STORE_BYTES = 4,
  parameter int ADDR_W      = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpCtl_t                     ctl,
  input  logic                       stVal,
  input  logic [ADDR_W-1:0]          stAddr,
  input  logic [STORE_BYTES-1:0]     stBe,
  input  logic [8*STORE_BYTES-1:0]   stData,
  output logic                       bufNe,
  output logic                       sameLine,
  output logic                       overlap,
  output logic                       ascending,
  output logic [ADDR_W-1:0]          busAddr,
  output logic [LINE_BYTES-1:0]      busBe,
  output logic [8*LINE_BYTES-1:0]    busData
);

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int SOFF_W = $clog2(STORE_BYTES);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int DATA_W = 8 * LINE_BYTES;

  logic [LINE_W-1:0]      lineQ;
  logic [LINE_BYTES-1:0]  maskQ;
  logic [DATA_W-1:0]      dataQ;
  logic [OFF_W-1:0]       lastOffQ;

  logic [LINE_W-1:0]        stLine;
  logic [OFF_W-SOFF_W-1:0]  wordIdx;
  logic [LINE_BYTES-1:0]    stMask;
  logic [DATA_W-1:0]        stLineData;
  logic [OFF_W-1:0]         lowOff;
  logic [OFF_W-1:0]         highOff;

  assign stLine     = stAddr[ADDR_W-1:OFF_W];
  assign wordIdx    = stAddr[OFF_W-1:SOFF_W];
  assign stMask     = LINE_BYTES'(stBe) << (int'(wordIdx) * STORE_BYTES);
  assign stLineData = DATA_W'(stData) << (int'(wordIdx) * 8 * STORE_BYTES);

  always_comb begin
    lowOff  = '0;
    highOff = '0;
    for (int i = LINE_BYTES - 1; i >= 0; i--) begin
      if (stMask[i]) lowOff = OFF_W'(i);
    end
    for (int i = 0; i < LINE_BYTES; i++) begin
      if (stMask[i]) highOff = OFF_W'(i);
    end
  end

  assign bufNe     = |maskQ;
  assign sameLine  = (lineQ == stLine);
  assign overlap   = |(stMask & maskQ);
  assign ascending = (lowOff > lastOffQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineQ    <= '0;
      maskQ    <= '0;
      dataQ    <= '0;
      lastOffQ <= '0;
    end else if (ctl.clearBuf) begin
      maskQ <= '0;
    end else if (ctl.loadStore) begin
      if (ctl.newLine) begin
        lineQ    <= stLine;
        maskQ    <= stMask;
        lastOffQ <= highOff;
      end else begin
        maskQ    <= maskQ | stMask;
        lastOffQ <= (highOff > lastOffQ) ? highOff : lastOffQ;
      end
      for (int i = 0; i < LINE_BYTES; i++) begin
        if (stMask[i]) dataQ[8*i +: 8] <= stLineData[8*i +: 8];
      end
    end
  end

  logic [LINE_W-1:0]     lineSel;
  logic [LINE_BYTES-1:0] maskSel;
  logic [DATA_W-1:0]     dataSel;

  assign lineSel = ctl.selDirect ? stLine     : lineQ;
  assign maskSel = ctl.selDirect ? stMask     : maskQ;
  assign dataSel = ctl.selDirect ? stLineData : dataQ;

  always_comb begin
    for (int i = 0; i < LINE_BYTES; i++) begin
      busData[8*i +: 8] = maskSel[i] ? dataSel[8*i +: 8] : 8'h00;
    end
  end

  assign busAddr = {lineSel, {OFF_W{1'b0}}};
  assign busBe   = maskSel;

  // R5: a drain handshake leaves the buffer empty
  assert_clear_empties_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearBuf |=> !bufNe);

  // R2: merging keeps the line and never drops a held byte
  assert_merge_keeps_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadStore && !ctl.newLine && !ctl.clearBuf) |=>
      ((lineQ == $past(lineQ)) && ((maskQ & $past(maskQ)) == $past(maskQ))));

  // R9: stores arrive word aligned
  assert_aligned_R9: assert property (@(posedge clk) disable iff (!rstN)
    stVal |-> (stAddr[SOFF_W-1:0] == '0));

endmodule

// File: rtl/smbCtrl.sv
module smbCtrl
  import smbPkg::*;
#(
  parameter int LIMIT_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stVal,
  input  logic               regCd,
  input  logic               regWt,
  input  logic               regWc,
  input  logic               regWs,
  input  logic               pageCd,
  input  logic               pageWt,
  input  logic               flushReq,
  input  logic [LIMIT_W-1:0] wsLimit,
  input  logic               busRdy,
  input  logic               busDone,
  input  logic               bufNe,
  input  logic               sameLine,
  input  logic               overlap,
  input  logic               ascending,
  output dpCtl_t             ctl,
  output logic               stAccept,
  output logic               busVal
);

  localparam int CNT_W = LIMIT_W + 1;

  wrMode_e           mode;
  wrMode_e           bufModeQ;
  logic [CNT_W-1:0]  cntQ;
  logic [CNT_W-1:0]  effLim;
  logic              isBuffered;
  logic              mergeOk;
  logic              needDrain;
  logic              serialOk;

  assign mode       = resolveMode(regCd, regWt, regWc, regWs, pageCd, pageWt);
  assign isBuffered = (mode == MODE_COMBINE) || (mode == MODE_BURST);
  assign mergeOk    = bufNe && sameLine && (bufModeQ == mode) &&
                      ((mode == MODE_COMBINE) || (ascending && !overlap));
  assign needDrain  = bufNe && (flushReq || (stVal && !(isBuffered && mergeOk)));
  assign effLim     = (wsLimit == '0) ? CNT_W'(1) : CNT_W'(wsLimit);
  assign serialOk   = (cntQ < effLim);

  always_comb begin
    ctl      = '0;
    stAccept = 1'b0;
    busVal   = 1'b0;
    if (needDrain) begin
      busVal       = 1'b1;
      ctl.clearBuf = busRdy;
    end else if (stVal) begin
      if (isBuffered) begin
        stAccept      = 1'b1;
        ctl.loadStore = 1'b1;
        ctl.newLine   = !bufNe;
      end else begin
        ctl.selDirect = 1'b1;
        busVal        = (mode != MODE_SERIAL) || serialOk;
        stAccept      = busVal && busRdy;
      end
    end
  end

  logic cntInc;
  logic cntDec;
  assign cntInc = busVal && busRdy;
  assign cntDec = busDone && (cntQ != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufModeQ <= MODE_SINGLE;
      cntQ     <= '0;
    end else begin
      if (ctl.loadStore && ctl.newLine) bufModeQ <= mode;
      if (cntInc && !cntDec && (cntQ != '1)) cntQ <= cntQ + 1'b1;
      else if (cntDec && !cntInc) cntQ <= cntQ - 1'b1;
    end
  end

  // R6: a serialize store is only taken below the cap
  assert_serial_cap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stAccept && (mode == MODE_SERIAL)) |-> (cntQ < effLim));

  // R6: a completion with no new issue lowers the count by one
  assert_cnt_dec_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busDone && !(busVal && busRdy) && (cntQ != '0)) |=> (cntQ == $past(cntQ) - 1'b1));

  // R5: no store is taken while the buffer is draining
  assert_drain_blocks_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busVal && !ctl.selDirect) |-> !stAccept);

  // R8: count starts at zero out of reset
  assert_reset_cnt_R8: assert property (@(posedge clk)
    $rose(rstN) |-> (cntQ == '0));

endmodule

// File: rtl/storeMergeBuffer.sv
module storeMergeBuffer
  import smbPkg::*;
#(
  parameter int LINE_BYTES  = 32,
  parameter int STORE_BYTES = 4,
  parameter int ADDR_W      = 32,
  parameter int LIMIT_W     = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      stVal,
  output logic                      stAccept,
  input  logic [ADDR_W-1:0]         stAddr,
  input  logic [STORE_BYTES-1:0]    stBe,
  input  logic [8*STORE_BYTES-1:0]  stData,
  input  logic                      regCd,
  input  logic                      regWt,
  input  logic                      regWc,
  input  logic                      regWs,
  input  logic                      pageCd,
  input  logic                      pageWt,
  input  logic                      flushReq,
  input  logic [LIMIT_W-1:0]        wsLimit,
  output logic                      busVal,
  input  logic                      busRdy,
  output logic [ADDR_W-1:0]         busAddr,
  output logic [LINE_BYTES-1:0]     busBe,
  output logic [8*LINE_BYTES-1:0]   busData,
  input  logic                      busDone
);

  dpCtl_t ctl;
  logic   bufNe;
  logic   sameLine;
  logic   overlap;
  logic   ascending;

  smbCtrl #(.LIMIT_W(LIMIT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .stVal     (stVal),
    .regCd     (regCd),
    .regWt     (regWt),
    .regWc     (regWc),
    .regWs     (regWs),
    .pageCd    (pageCd),
    .pageWt    (pageWt),
    .flushReq  (flushReq),
    .wsLimit   (wsLimit),
    .busRdy    (busRdy),
    .busDone   (busDone),
    .bufNe     (bufNe),
    .sameLine  (sameLine),
    .overlap   (overlap),
    .ascending (ascending),
    .ctl       (ctl),
    .stAccept  (stAccept),
    .busVal    (busVal)
  );

  smbData #(
    .LINE_BYTES  (LINE_BYTES),
    .STORE_BYTES (STORE_BYTES),
    .ADDR_W      (ADDR_W)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .stVal     (stVal),
    .stAddr    (stAddr),
    .stBe      (stBe),
    .stData    (stData),
    .bufNe     (bufNe),
    .sameLine  (sameLine),
    .overlap   (overlap),
    .ascending (ascending),
    .busAddr   (busAddr),
    .busBe     (busBe),
    .busData   (busData)
  );

endmodule

// File: tb/test_storeMergeBuffer.sv
`timescale 1ns/1ps
module test_storeMergeBuffer;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         stVal = 1'b0;
  logic         stAccept;
  logic [31:0]  stAddr = '0;
  logic [3:0]   stBe = '0;
  logic [31:0]  stData = '0;
  logic [5:0]   attr = '0;   // {regCd,regWt,regWc,regWs,pageCd,pageWt}
  logic         flushReq = 1'b0;
  logic [2:0]   wsLimit = '0;
  logic         busVal;
  logic         busRdy = 1'b1;
  logic [31:0]  busAddr;
  logic [31:0]  busBe;
  logic [255:0] busData;
  logic         busDone = 1'b0;

  always #2.5 clk = ~clk;

  storeMergeBuffer i_storeMergeBuffer (
    .clk(clk), .rstN(rstN), .stVal(stVal), .stAccept(stAccept),
    .stAddr(stAddr), .stBe(stBe), .stData(stData),
    .regCd(attr[5]), .regWt(attr[4]), .regWc(attr[3]), .regWs(attr[2]),
    .pageCd(attr[1]), .pageWt(attr[0]), .flushReq(flushReq), .wsLimit(wsLimit),
    .busVal(busVal), .busRdy(busRdy), .busAddr(busAddr), .busBe(busBe),
    .busData(busData), .busDone(busDone)
  );

  localparam logic [5:0] A_WC  = 6'b101000;
  localparam logic [5:0] A_WBP = 6'b101001;
  localparam logic [5:0] A_WBR = 6'b111000;
  localparam logic [5:0] A_WS  = 6'b100100;
  localparam logic [5:0] A_UC  = 6'b100000;
  localparam logic [5:0] A_PCD = 6'b001010;
  localparam logic [5:0] A_CCH = 6'b001000;

  int checks = 0;
  int errors = 0;
  string curReq = "R8";
  bit finished = 0;

  // reference state
  logic [7:0] mB [32];
  bit         mV [32];
  int         mLine = 0;
  int         mMode = 0;
  int         mLast = 0;
  int         mCnt = 0;

  // expectation of the current cycle
  bit           eVal, eAcc, doClear, doLoad;
  logic [31:0]  eAddr, eBe;
  logic [255:0] eData;
  int           sMode, sLine, sHigh;
  bit           sMask [32];
  logic [7:0]   sByte [32];
  bit           lastAcc;

  int           nWr = 0;
  logic [31:0]  lastAddr = '0;
  logic [31:0]  lastBe = '0;
  logic [255:0] lastData = '0;

  task automatic chk(input bit ok, input string what, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", curReq, what, act, exp);
    end
  endtask

  function automatic bit mEmpty();
    for (int i = 0; i < 32; i++) if (mV[i]) return 0;
    return 1;
  endfunction

  // 0 single, 1 combine, 2 burst, 3 serialize
  function automatic int pickMode(input logic [5:0] a);
    bit cd, wt;
    cd = a[5] || a[1];
    wt = a[4] || a[0];
    if (!cd) return 0;
    if (a[3]) return wt ? 2 : 1;
    if (a[2]) return 3;
    return 0;
  endfunction

  task automatic evalModel();
    bit ne, merge, drain, anyOv;
    int lowOff, lim, w;
    eVal = 0; eAcc = 0; doClear = 0; doLoad = 0;
    eAddr = '0; eBe = '0; eData = '0;
    sMode = pickMode(attr);
    sLine = int'(stAddr >> 5);
    w = int'((stAddr >> 2) & 32'd7);
    lowOff = 99; sHigh = -1; anyOv = 0;
    for (int i = 0; i < 32; i++) begin sMask[i] = 0; sByte[i] = 8'h00; end
    for (int k = 0; k < 4; k++) begin
      if (stBe[k]) begin
        sMask[w*4+k] = 1;
        sByte[w*4+k] = stData[8*k +: 8];
        if (lowOff == 99) lowOff = w*4+k;
        sHigh = w*4+k;
        if (mV[w*4+k]) anyOv = 1;
      end
    end
    ne = !mEmpty();
    merge = ne && (sMode == 1 || sMode == 2) && sLine == mLine && mMode == sMode &&
            (sMode == 1 || (lowOff > mLast && !anyOv));
    drain = ne && (flushReq || (stVal && !merge));
    lim = (wsLimit == 0) ? 1 : int'(wsLimit);
    if (drain) begin
      eVal = 1;
      eAddr = 32'(mLine) << 5;
      for (int i = 0; i < 32; i++) if (mV[i]) begin eBe[i] = 1'b1; eData[8*i +: 8] = mB[i]; end
      doClear = busRdy;
    end else if (stVal) begin
      if (sMode == 1 || sMode == 2) begin
        eAcc = 1; doLoad = 1;
      end else begin
        eVal = (sMode != 3) || (mCnt < lim);
        eAcc = eVal && busRdy;
        eAddr = 32'(sLine) << 5;
        for (int i = 0; i < 32; i++) if (sMask[i]) begin eBe[i] = 1'b1; eData[8*i +: 8] = sByte[i]; end
      end
    end
  endtask

  task automatic updateModel();
    bit ne;
    ne = !mEmpty();
    if (eVal && busRdy) mCnt++;
    if (busDone && mCnt > 0) mCnt--;
    if (doClear) for (int i = 0; i < 32; i++) mV[i] = 0;
    if (doLoad) begin
      if (!ne) begin
        mLine = sLine; mMode = sMode; mLast = sHigh;
      end else if (sHigh > mLast) mLast = sHigh;
      for (int i = 0; i < 32; i++) if (sMask[i]) begin mV[i] = 1; mB[i] = sByte[i]; end
    end
  endtask

  task automatic step();
    #1;
    evalModel();
    chk(busVal == eVal, "busVal", 256'(busVal), 256'(eVal));
    chk(stAccept == eAcc, "stAccept", 256'(stAccept), 256'(eAcc));
    if (eVal) begin
      chk(busAddr == eAddr, "busAddr", 256'(busAddr), 256'(eAddr));
      chk(busBe == eBe, "busBe", 256'(busBe), 256'(eBe));
      chk(busData == eData, "busData", busData, eData);
    end
    if (busVal && busRdy) begin
      nWr++; lastAddr = busAddr; lastBe = busBe; lastData = busData;
    end
    lastAcc = eAcc;
    @(posedge clk);
    updateModel();
    @(negedge clk);
  endtask

  task automatic store(input logic [31:0] a, input logic [3:0] be,
                       input logic [31:0] d, input logic [5:0] at);
    stVal = 1; stAddr = a; stBe = be; stData = d; attr = at;
    for (int n = 0; n < 40; n++) begin
      step();
      if (lastAcc) break;
    end
    stVal = 0;
  endtask

  task automatic flushAll();
    flushReq = 1;
    for (int n = 0; n < 20; n++) begin
      step();
      if (mEmpty()) break;
    end
    flushReq = 0;
  endtask

  task automatic retire();
    busDone = 1;
    for (int n = 0; n < 40; n++) begin
      if (mCnt == 0) break;
      step();
    end
    busDone = 0;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int w0;
    for (int i = 0; i < 32; i++) begin mV[i] = 0; mB[i] = 8'h00; end
    repeat (3) @(negedge clk);
    #1;
    // R8: reset state
    curReq = "R8";
    chk(busVal == 1'b0, "reset busVal", 256'(busVal), 256'(0));
    chk(stAccept == 1'b0, "reset stAccept", 256'(stAccept), 256'(0));
    @(negedge clk);
    rstN = 1;
    step(); step();

    // R2 + R1: combine, last value wins, one write
    curReq = "R2";
    w0 = nWr;
    store(32'h100, 4'hF, 32'h11223344, A_WC);
    store(32'h100, 4'h1, 32'h000000AA, A_WC);
    store(32'h10C, 4'hC, 32'h55667788, A_WC);
    chk(nWr == w0, "R2 no write yet", 256'(nWr), 256'(w0));
    flushAll();
    chk(nWr == w0 + 1, "R2 writes", 256'(nWr), 256'(w0 + 1));
    chk(lastBe == 32'h0000C00F, "R2 mask", 256'(lastBe), 256'(32'h0000C00F));
    chk(lastData[7:0] == 8'hAA, "R2 byte0", 256'(lastData[7:0]), 256'(8'hAA));
    chk(lastData[15:8] == 8'h33, "R2 byte1", 256'(lastData[15:8]), 256'(8'h33));
    chk(lastData[127:112] == 16'h5566, "R9 bytes14-15", 256'(lastData[127:112]), 256'(16'h5566));
    chk(lastAddr == 32'h100, "R9 addr", 256'(lastAddr), 256'(32'h100));

    // R3 / R4: burst ascending merge, repeat byte drains, descending drains
    curReq = "R3";
    w0 = nWr;
    store(32'h204, 4'h1, 32'h000000AB, A_WBP);
    store(32'h204, 4'h2, 32'h0000CD00, A_WBP);
    chk(nWr == w0, "R3 ascending merged", 256'(nWr), 256'(w0));
    curReq = "R4";
    store(32'h204, 4'h2, 32'h0000EF00, A_WBP);
    chk(nWr == w0 + 1, "R4 repeat byte drains", 256'(nWr), 256'(w0 + 1));
    chk(lastBe == 32'h30, "R4 first burst mask", 256'(lastBe), 256'(32'h30));
    curReq = "R3";
    store(32'h200, 4'h1, 32'h00000011, A_WBR);
    chk(nWr == w0 + 2, "R3 descending drains", 256'(nWr), 256'(w0 + 2));
    chk(lastData[47:40] == 8'hEF, "R4 second byte5", 256'(lastData[47:40]), 256'(8'hEF));
    flushAll();
    chk(lastBe == 32'h1, "R3 final mask", 256'(lastBe), 256'(32'h1));

    // R5: line change, mode change, page cache-disable forcing combine
    curReq = "R5";
    w0 = nWr;
    store(32'h300, 4'hF, 32'hA1A2A3A4, A_WC);
    store(32'h320, 4'hF, 32'hB1B2B3B4, A_WC);
    chk(nWr == w0 + 1, "R5 line change", 256'(nWr), 256'(w0 + 1));
    chk(lastAddr == 32'h300, "R5 drained line", 256'(lastAddr), 256'(32'h300));
    store(32'h324, 4'hF, 32'hC1C2C3C4, A_WBR);
    chk(nWr == w0 + 2, "R5 mode change", 256'(nWr), 256'(w0 + 2));
    flushAll();
    curReq = "R1";
    store(32'h340, 4'hF, 32'h01020304, A_PCD);
    store(32'h344, 4'hF, 32'h05060708, A_PCD);
    chk(nWr == w0 + 3, "R1 page cd merges", 256'(nWr), 256'(w0 + 3));
    flushAll();
    chk(lastBe == 32'hFF, "R1 merged mask", 256'(lastBe), 256'(32'hFF));

    // R9: back-pressure holds the drain
    curReq = "R9";
    store(32'h400, 4'h3, 32'h00001234, A_WC);
    busRdy = 0; flushReq = 1;
    step(); step(); step();
    busRdy = 1;
    flushAll();
    chk(lastBe == 32'h3, "R9 held drain mask", 256'(lastBe), 256'(32'h3));

    // R6: serialize cap, limit 2 then limit 0
    curReq = "R6";
    retire();
    wsLimit = 3'd2;
    w0 = nWr;
    store(32'h500, 4'hF, 32'h1, A_WS);
    store(32'h504, 4'hF, 32'h2, A_WS);
    stVal = 1; stAddr = 32'h508; stBe = 4'hF; stData = 32'h3; attr = A_WS;
    for (int n = 0; n < 4; n++) begin
      step();
      chk(!lastAcc, "R6 stall at cap", 256'(lastAcc), 256'(0));
    end
    busDone = 1; step(); busDone = 0;
    store(32'h508, 4'hF, 32'h3, A_WS);
    chk(nWr == w0 + 3, "R6 writes", 256'(nWr), 256'(w0 + 3));
    retire();
    wsLimit = 3'd0;
    store(32'h520, 4'h1, 32'h9, A_WS);
    stVal = 1; stAddr = 32'h524; stBe = 4'h1; attr = A_WS;
    step(); step();
    chk(!lastAcc, "R6 limit 0 acts as 1", 256'(lastAcc), 256'(0));
    stVal = 0;
    retire();

    // R7: single write drains buffer first; cacheable is single
    curReq = "R7";
    w0 = nWr;
    store(32'h600, 4'hF, 32'hDEADBEEF, A_WC);
    store(32'h604, 4'hF, 32'hCAFEF00D, A_UC);
    chk(nWr == w0 + 2, "R7 drain then single", 256'(nWr), 256'(w0 + 2));
    chk(lastBe == 32'hF0, "R7 single mask", 256'(lastBe), 256'(32'hF0));
    store(32'h700, 4'h8, 32'h77000000, A_CCH);
    chk(nWr == w0 + 3, "R1 cacheable single", 256'(nWr), 256'(w0 + 3));
    chk(lastData[31:24] == 8'h77, "R9 single byte3", 256'(lastData[31:24]), 256'(8'h77));
    retire();
    step(); step();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule